// File: doc/BRIEF.md
# Pipelined Synchronous Burst SRAM

A synthesizable model of a small synchronous burst memory. The word is 18 bits wide and is split into two 9-bit byte lanes. Every control input is sampled on the rising clock edge. An access is opened by one of two address strobes, both active low. The processor strobe always opens a read. The controller strobe opens either a read or a write, chosen by the write controls on that same edge. After an access is opened, a step input walks a 2-bit burst counter over the two low address bits. The counter follows either linear or interleaved order and wraps after four beats. Write controls on any later edge write the current beat.

Read data is pipelined. The address is registered on the access edge, and the word reaches the output register on the next edge. The output drives only while output enable is low, a valid read sits in the output stage, and sleep is low. A write or a deselect releases the output one edge later. The undriven state is modelled as `q = 0` with `q_drive = 0`. The block has no back-pressure: there is no valid/ready handshake. Every edge is an access slot, and the caller must present controls on time.

Top module: `burst_sram`

## Requirements
- R1: After reset `q_drive` is 0 and `q` is 0 until a read has been opened and has completed.
- R2: On an edge where `cpu_strb_n` = 0 and the enables are active (`en0_n` = 0, `en1` = 1), a read of `addr` is opened and the write controls are ignored. The word appears on `q` with `q_drive` = 1 after the following edge, provided `out_en_n` = 0.
- R3: On an edge where `ctl_strb_n` = 0, `cpu_strb_n` = 1 and the enables are active, a qualified write stores `din` at `addr` on that edge. Without a qualified write, the edge opens a read that behaves as in R2.
- R4: If the enables are inactive on a strobe edge, the block is deselected. It performs no read or write until the next strobe, and `q_drive` is 0 after the next edge.
- R5: On an edge after an access has been opened, with no strobe low, a qualified write stores `din` at the current burst address. A processor-strobe read followed by a write edge therefore writes the same address.
- R6: `wr_all_n` = 0 qualifies a write of both lanes, whatever `lane_we_n` holds.
- R7: With `wr_all_n` = 1, a write is qualified only when `wr_byte_n` = 0 and `lane_we_n` is not 2'b11. Bit 0 of `lane_we_n` (active low) selects `q[8:0]` and bit 1 selects `q[17:9]`. Unselected lanes keep their contents.
- R8: With `order_il` = 0, each edge where `step_n` = 0 and no strobe is low moves the low two address bits to base+1, +2, +3, then back to base (mod 4). A read is performed at the new address. The upper bits stay fixed.
- R9: With `order_il` = 1, the low two address bits of beat k are base XOR k.
- R10: After an edge that performs a write, `q_drive` is 0 until a later read completes. This holds even if a read was pending.
- R11: While `out_en_n` = 1, `q_drive` = 0 and `q` = 0. Dropping `out_en_n` shows the registered word with no clock edge.
- R12: While `sleep` = 1, strobes, steps and writes are ignored, memory contents are kept, and `q_drive` = 0.
- R13: A strobe during a burst abandons that burst and loads the new address. The read that was already in the pipeline still completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | ADDR_W | Word address, sampled on strobe edges |
| din | input | 18 | Write data |
| cpu_strb_n | input | 1 | Processor address strobe, active low; always opens a read |
| ctl_strb_n | input | 1 | Controller address strobe, active low; opens a read or a write |
| step_n | input | 1 | Burst advance, active low |
| en0_n | input | 1 | Chip enable, active low |
| en1 | input | 1 | Chip enable, active high |
| out_en_n | input | 1 | Output enable, active low, asynchronous |
| wr_all_n | input | 1 | Global write, active low |
| wr_byte_n | input | 1 | Byte-write qualifier, active low |
| lane_we_n | input | 2 | Per-lane write enables, active low |
| order_il | input | 1 | Burst order: 0 linear, 1 interleaved |
| sleep | input | 1 | Low-power sleep, active high |
| q | output | 18 | Read data, 0 when not driven |
| q_drive | output | 1 | High while the output would be driven |

## Verification
The bench builds the block with its defaults: `ADDR_W` = 6 gives 64 words of two 9-bit lanes. With that depth, every address is filled by a write and then used as a burst start in both linear and interleaved order. Each of those bursts is checked through all four beats and the wrap back to the start beat. The small depth also leaves time for directed sequences on lane masks, deselect, strobe pre-emption, write-after-read and sleep. In each of these, expected words come from a bench-side copy of the memory and from arithmetic on the burst address.

// File: rtl/burst_sram_pkg.sv
`timescale 1ns/1ps
package burst_sram_pkg;
  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } sram_op_e;
endpackage

// File: rtl/burst_sram_order.sv
`timescale 1ns/1ps
module burst_sram_order #(
  parameter int BURST_W = 2
) (
  input  logic [BURST_W-1:0] base_lo,
  input  logic [BURST_W-1:0] beat,
  input  logic               interleave,
  output logic [BURST_W-1:0] lo
);
  // Linear order adds the beat count; interleaved order flips the start bits.
  always_comb begin
    if (interleave) lo = base_lo ^ beat;
    else            lo = base_lo + beat;
  end
endmodule

// File: rtl/burst_sram_ctrl.sv
`timescale 1ns/1ps
module burst_sram_ctrl
  import burst_sram_pkg::*;
#(
  parameter int ADDR_W  = 6,
  parameter int LANES   = 2,
  parameter int BURST_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              cpu_strb_n,
  input  logic              ctl_strb_n,
  input  logic              step_n,
  input  logic              en_ok,
  input  logic              wr_all_n,
  input  logic              wr_byte_n,
  input  logic [LANES-1:0]  lane_we_n,
  input  logic              order_il,
  input  logic              sleep,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [LANES-1:0]  mem_lanes,
  output logic              rd_pend,
  output logic [ADDR_W-1:0] rd_addr
);
  logic [ADDR_W-1:0]  base_q;
  logic [BURST_W-1:0] beat_q, beat_nx, cont_lo;
  logic               active_q;
  logic               start, wq;
  logic [ADDR_W-1:0]  cont_addr, tgt;
  sram_op_e           op;

  assign start   = !cpu_strb_n || !ctl_strb_n;
  assign wq      = !wr_all_n || (!wr_byte_n && (lane_we_n != {LANES{1'b1}}));
  assign beat_nx = step_n ? beat_q : beat_q + 1'b1;

  burst_sram_order #(.BURST_W(BURST_W)) u_order (
    .base_lo   (base_q[BURST_W-1:0]),
    .beat      (beat_nx),
    .interleave(order_il),
    .lo        (cont_lo)
  );

  assign cont_addr = {base_q[ADDR_W-1:BURST_W], cont_lo};

  always_comb begin
    op  = OP_NONE;
    tgt = addr;
    if (!sleep) begin
      if (start) begin
        if (en_ok) begin
          if (!cpu_strb_n) op = OP_READ;
          else if (wq)     op = OP_WRITE;
          else             op = OP_READ;
        end
      end else if (active_q) begin
        tgt = cont_addr;
        if (wq)          op = OP_WRITE;
        else if (!step_n) op = OP_READ;
      end
    end
  end

  assign mem_we    = (op == OP_WRITE);
  assign mem_addr  = tgt;
  assign mem_lanes = !wr_all_n ? {LANES{1'b1}} : ~lane_we_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q   <= '0;
      beat_q   <= '0;
      active_q <= 1'b0;
      rd_pend  <= 1'b0;
      rd_addr  <= '0;
    end else begin
      rd_pend <= (op == OP_READ);
      rd_addr <= tgt;
      if (!sleep) begin
        if (start) begin
          base_q   <= addr;
          beat_q   <= '0;
          active_q <= en_ok;
        end else if (active_q) begin
          beat_q <= beat_nx;
        end
      end
    end
  end

  AST_CPU_STRB_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n) !cpu_strb_n |-> !mem_we); // R2
  AST_DESEL_NO_READ: assert property (@(posedge clk) disable iff (!rst_n) (start && !en_ok && !sleep) |=> !rd_pend); // R4
  AST_SLEEP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n) sleep |-> !mem_we); // R12
  AST_SLEEP_NO_READ: assert property (@(posedge clk) disable iff (!rst_n) sleep |=> !rd_pend); // R12
endmodule

// File: rtl/burst_sram_array.sv
`timescale 1ns/1ps
module burst_sram_array #(
  parameter int ADDR_W = 6,
  parameter int LANE_W = 9,
  parameter int LANES  = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    we,
  input  logic [ADDR_W-1:0]       wr_addr,
  input  logic [LANES-1:0]        wr_lanes,
  input  logic [LANE_W*LANES-1:0] din,
  input  logic                    rd_pend,
  input  logic [ADDR_W-1:0]       rd_addr,
  output logic [LANE_W*LANES-1:0] q_reg,
  output logic                    q_vld
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem_l [DEPTH];
    always_ff @(posedge clk) begin
      if (we && wr_lanes[g]) mem_l[wr_addr] <= din[g*LANE_W +: LANE_W];
      q_reg[g*LANE_W +: LANE_W] <= mem_l[rd_addr];
    end
  end

  // A write edge cancels any read still waiting to reach the output.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_vld <= 1'b0;
    else        q_vld <= rd_pend && !we;
  end
endmodule

// File: rtl/burst_sram.sv
`timescale 1ns/1ps
module burst_sram #(
  parameter int ADDR_W  = 6,
  parameter int LANE_W  = 9,
  parameter int LANES   = 2,
  parameter int BURST_W = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANE_W*LANES-1:0] din,
  input  logic                    cpu_strb_n,
  input  logic                    ctl_strb_n,
  input  logic                    step_n,
  input  logic                    en0_n,
  input  logic                    en1,
  input  logic                    out_en_n,
  input  logic                    wr_all_n,
  input  logic                    wr_byte_n,
  input  logic [LANES-1:0]        lane_we_n,
  input  logic                    order_il,
  input  logic                    sleep,
  output logic [LANE_W*LANES-1:0] q,
  output logic                    q_drive
);
  localparam int WORD_W = LANE_W * LANES;

  logic              mem_we, rd_pend, q_vld;
  logic [ADDR_W-1:0] mem_addr, rd_addr;
  logic [LANES-1:0]  mem_lanes;
  logic [WORD_W-1:0] q_reg;

  burst_sram_ctrl #(.ADDR_W(ADDR_W), .LANES(LANES), .BURST_W(BURST_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .addr      (addr),
    .cpu_strb_n(cpu_strb_n),
    .ctl_strb_n(ctl_strb_n),
    .step_n    (step_n),
    .en_ok     (!en0_n && en1),
    .wr_all_n  (wr_all_n),
    .wr_byte_n (wr_byte_n),
    .lane_we_n (lane_we_n),
    .order_il  (order_il),
    .sleep     (sleep),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_lanes (mem_lanes),
    .rd_pend   (rd_pend),
    .rd_addr   (rd_addr)
  );

  burst_sram_array #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES)) u_array (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (mem_we),
    .wr_addr (mem_addr),
    .wr_lanes(mem_lanes),
    .din     (din),
    .rd_pend (rd_pend),
    .rd_addr (rd_addr),
    .q_reg   (q_reg),
    .q_vld   (q_vld)
  );

  assign q_drive = q_vld && !out_en_n && !sleep;
  assign q       = q_drive ? q_reg : '0;

  AST_WRITE_RELEASES_Q: assert property (@(posedge clk) disable iff (!rst_n) mem_we |=> !q_vld); // R10
  AST_OE_GATES_Q: assert property (@(posedge clk) disable iff (!rst_n) out_en_n |-> (!q_drive && q == '0)); // R11
  AST_READ_PIPE: assert property (@(posedge clk) disable iff (!rst_n) (rd_pend && !mem_we) |=> q_vld); // R2
endmodule

// File: tb/burst_sram_bench.sv
`timescale 1ns/1ps
module burst_sram_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [5:0]  addr;
  logic [17:0] din;
  logic        cpu_strb_n, ctl_strb_n, step_n, en0_n, en1, out_en_n;
  logic        wr_all_n, wr_byte_n, order_il, sleep;
  logic [1:0]  lane_we_n;
  logic [17:0] q;
  logic        q_drive;

  int nchk = 0;
  int nerr = 0;
  bit done = 0;
  logic [17:0] model [64];

  burst_sram u_burst_sram (
    .clk(clk), .rst_n(rst_n), .addr(addr), .din(din),
    .cpu_strb_n(cpu_strb_n), .ctl_strb_n(ctl_strb_n), .step_n(step_n),
    .en0_n(en0_n), .en1(en1), .out_en_n(out_en_n),
    .wr_all_n(wr_all_n), .wr_byte_n(wr_byte_n), .lane_we_n(lane_we_n),
    .order_il(order_il), .sleep(sleep), .q(q), .q_drive(q_drive)
  );

  always #5 clk = ~clk;

  function automatic logic [17:0] dpat(int a, int salt);
    return 18'((a * 4691) + (salt * 1237) + 341);
  endfunction

  function automatic logic [5:0] beat_addr(logic [5:0] a, int k, logic il);
    logic [1:0] lo;
    lo = il ? (a[1:0] ^ 2'(k)) : 2'(a[1:0] + 2'(k));
    return {a[5:2], lo};
  endfunction

  task automatic chk(input string req, input logic [17:0] act, input logic [17:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic set_idle();
    cpu_strb_n = 1; ctl_strb_n = 1; step_n = 1; en0_n = 0; en1 = 1;
    wr_all_n = 1; wr_byte_n = 1; lane_we_n = 2'b11; sleep = 0; out_en_n = 0;
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic wr_ctl(input logic [5:0] a, input logic [17:0] d,
                        input logic all_n, input logic byte_n, input logic [1:0] ln);
    ctl_strb_n = 0; addr = a; din = d; wr_all_n = all_n; wr_byte_n = byte_n; lane_we_n = ln;
    tick();
    set_idle();
  endtask

  task automatic rd_cpu(input logic [5:0] a, output logic [17:0] d, output logic drv);
    cpu_strb_n = 0; addr = a;
    tick();
    set_idle();
    tick();
    d = q; drv = q_drive;
  endtask

  logic [17:0] rd;
  logic        dv;

  initial begin
    #2_000_000;
    if (!done) begin
      nerr++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin
    set_idle(); order_il = 0; addr = 0; din = 0;
    rst_n = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    tick();
    chk("R1 drive after reset", {17'd0, q_drive}, 18'd0);
    chk("R1 q after reset", q, 18'd0);

    // Fill every word through the controller strobe (R3, R6).
    for (int a = 0; a < 64; a++) begin
      wr_ctl(6'(a), dpat(a, 0), 1'b0, 1'b1, 2'b11);
      model[a] = dpat(a, 0);
    end
    tick();
    chk("R10 no drive after writes", {17'd0, q_drive}, 18'd0);

    // Burst sweep in both orders from every start (R2, R8, R9).
    for (int m = 0; m < 2; m++) begin
      order_il = m[0];
      for (int a = 0; a < 64; a++) begin
        cpu_strb_n = 0; addr = 6'(a);
        tick();
        set_idle(); step_n = 0;
        for (int s = 0; s < 4; s++) begin
          tick();
          chk(m ? "R9 interleaved beat" : "R8 linear beat", q, model[beat_addr(6'(a), s, m[0])]);
          chk("R2 drive on read", {17'd0, q_drive}, 18'd1);
        end
        step_n = 1;
        tick();
        chk(m ? "R9 wrap" : "R8 wrap", q, model[a]);
      end
    end
    order_il = 0;
    tick();

    // R3 read through the controller strobe.
    ctl_strb_n = 0; addr = 6'd17;
    tick(); set_idle(); tick();
    chk("R3 controller read", q, model[17]);

    // R2 write controls ignored on processor strobe edge.
    cpu_strb_n = 0; addr = 6'd5; wr_all_n = 0; din = 18'h3FFFF;
    tick(); set_idle(); tick();
    chk("R2 read despite write ctl", q, model[5]);
    rd_cpu(6'd5, rd, dv);
    chk("R2 no write on cpu strobe", rd, model[5]);

    // R6 global write overrides lane enables.
    wr_ctl(6'd6, 18'h2A5A5, 1'b0, 1'b0, 2'b11);
    model[6] = 18'h2A5A5;
    rd_cpu(6'd6, rd, dv);
    chk("R6 global write", rd, model[6]);

    // R7 lane subsets and unqualified writes.
    wr_ctl(6'd7, 18'h3FFFF, 1'b1, 1'b0, 2'b10);
    model[7] = {model[7][17:9], 9'h1FF};
    rd_cpu(6'd7, rd, dv);
    chk("R7 lane0 only", rd, model[7]);
    wr_ctl(6'd8, 18'h00000, 1'b1, 1'b0, 2'b01);
    model[8] = {9'h000, model[8][8:0]};
    rd_cpu(6'd8, rd, dv);
    chk("R7 lane1 only", rd, model[8]);
    wr_ctl(6'd9, 18'h12345, 1'b1, 1'b1, 2'b00);
    rd_cpu(6'd9, rd, dv);
    chk("R7 no byte qualifier", rd, model[9]);
    wr_ctl(6'd10, 18'h12345, 1'b1, 1'b0, 2'b11);
    rd_cpu(6'd10, rd, dv);
    chk("R7 no lanes selected", rd, model[10]);

    // R5 and R10: read then write edge at the same address.
    cpu_strb_n = 0; addr = 6'd11;
    tick(); set_idle();
    wr_byte_n = 0; lane_we_n = 2'b00; din = 18'h0BEEF;
    tick(); set_idle();
    chk("R10 write cancels pending read", {17'd0, q_drive}, 18'd0);
    tick();
    chk("R10 stays released", {17'd0, q_drive}, 18'd0);
    model[11] = 18'h0BEEF;
    rd_cpu(6'd11, rd, dv);
    chk("R5 continuation write", rd, model[11]);

    // R4 deselect: no read, no write until next strobe.
    ctl_strb_n = 0; addr = 6'd12; en0_n = 1; wr_all_n = 0; din = 18'h11111;
    tick(); set_idle();
    step_n = 0; wr_all_n = 0; din = 18'h22222;
    tick(); set_idle(); step_n = 0;
    tick(); set_idle();
    chk("R4 no drive when deselected", {17'd0, q_drive}, 18'd0);
    rd_cpu(6'd12, rd, dv);
    chk("R4 no write at start", rd, model[12]);
    rd_cpu(6'd13, rd, dv);
    chk("R4 no write on step", rd, model[13]);
    cpu_strb_n = 0; addr = 6'd14; en1 = 0;
    tick(); set_idle(); tick();
    chk("R4 second enable", {17'd0, q_drive}, 18'd0);

    // R11 output enable.
    cpu_strb_n = 0; addr = 6'd15;
    tick(); set_idle(); out_en_n = 1;
    tick();
    chk("R11 drive off", {17'd0, q_drive}, 18'd0);
    chk("R11 q zero", q, 18'd0);
    out_en_n = 0; #1;
    chk("R11 q after enable", q, model[15]);
    tick();

    // R13 strobe abandons burst.
    cpu_strb_n = 0; addr = 6'd20;
    tick(); set_idle(); step_n = 0;
    tick(); set_idle();
    chk("R13 first beat", q, model[20]);
    cpu_strb_n = 0; addr = 6'd40;
    tick(); set_idle();
    chk("R13 in-flight beat", q, model[21]);
    tick();
    chk("R13 new address", q, model[40]);

    // R12 sleep.
    cpu_strb_n = 0; addr = 6'd30;
    tick(); set_idle(); sleep = 1;
    tick();
    chk("R12 drive off in sleep", {17'd0, q_drive}, 18'd0);
    ctl_strb_n = 0; addr = 6'd31; wr_all_n = 0; din = 18'h33333;
    tick(); set_idle();
    rd_cpu(6'd31, rd, dv);
    chk("R12 contents kept", rd, model[31]);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule